// File: doc/BRIEF.md
# Energy-Detection Carrier Frequency Estimator

This block locates an unknown transmitter in a sampled spectrum. It takes a stream of per-bin power values coming out of an FFT. Several consecutive observation windows are summed bin by bin, and the sum is scaled down by a shift to give an averaged power spectral density. The averaged spectrum is then smoothed across frequency with a centred moving average. Each smoothed bin is compared against a decision threshold. The block reports whether any energy was detected and gives the centre bin of the widest contiguous occupied region, so that a receiver can retune without a control channel.

A state machine sequences one averaging period. `ST_IDLE` waits for a valid sample flagged as the first bin of a window. That sample is written, the configuration is latched, and the transition *start* leads to `ST_ACCUM`. `ST_ACCUM` takes `NBINS` valid samples per window. After the final bin of the final window, the transition *filled* leads to `ST_SCAN`. `ST_SCAN` visits one bin per cycle: it forms the smoothed value, tests it against the threshold and tracks runs of occupied bins. After the last bin, the transition *scanned* leads to `ST_REPORT`. `ST_REPORT` loads the result registers and raises the done pulse. Its unconditional transition *reported* returns to `ST_IDLE`.

Top module: `est_carrier_finder`

## Requirements
- R1: After reset, `det_flag`, `center_bin` and `done` are all 0.
- R2: A period begins only with a valid sample whose `pwr_sof` is 1, and that sample is bin 0. Valid samples presented while idle without `pwr_sof` are ignored. During accumulation, cycles with `pwr_valid` low are skipped. Samples arriving back to back fill bins 0 to NBINS-1 of window 0, then window 1, and so on.
- R3: The period covers 2^W windows, where W = `cfg_win_log2` clamped to 0..4. The averaged value of each bin is the floor of the window sum divided by 2^W.
- R4: The smoothing length is L = 2*`cfg_smooth_half`+1, with a half-width from 0 to 7. The window is centred on the bin under test, and bins outside 0..NBINS-1 count as zero. A bin is occupied when the mean of the averaged values across its window is strictly greater than `cfg_thresh`.
- R5: At the report, `det_flag` is 1 exactly when at least one bin is occupied.
- R6: `center_bin` is floor((first+last)/2), where first and last are the end bins of the longest contiguous run of occupied bins. If two runs are equally long, the lowest-indexed one is used.
- R7: When no bin is occupied, `center_bin` is 0.
- R8: `done` is a single-cycle pulse. It rises on the (NBINS+1)th rising edge after the edge that takes the final sample of a period. `det_flag` and `center_bin` keep their values until the next pulse.
- R9: Samples presented after the final sample of a period and before `done` rises are ignored. A sample with `pwr_sof` that is presented in the `done` cycle starts the next period.
- R10: The three configuration inputs are sampled when a period starts. Changes made during the period have no effect on that period's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_valid | input | 1 | Bin power sample present |
| pwr_sof | input | 1 | Sample is bin 0 of a window |
| pwr_data | input | PW | Bin power value |
| cfg_win_log2 | input | WLW | log2 of windows per period |
| cfg_smooth_half | input | HW | Smoothing half-width |
| cfg_thresh | input | PW | Decision threshold |
| det_flag | output | 1 | Signal present |
| center_bin | output | BW | Estimated centre bin |
| done | output | 1 | One-cycle result strobe |

## Verification
The end of one period and the start of the next can fall in the same cycle. The `done` strobe of period A is high in exactly the cycle in which a window-start sample of period B is accepted. The bench provokes this by feeding junk samples flagged as window starts throughout the scan of A, and then issuing B's first sample in the `done` cycle of A. It judges the outcome by comparing both reported results with independently modelled values: A must show no trace of the junk, and B must show no loss of its first bin.

// File: rtl/est_pkg.sv
package est_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_SCAN   = 2'd2,
        ST_REPORT = 2'd3
    } est_state_e;
endpackage

// File: rtl/est_psd_accum.sv
module est_psd_accum #(
    parameter int NBINS = 64,
    parameter int PW    = 16,
    parameter int AW    = 20,
    localparam int BW   = $clog2(NBINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_first,
    input  logic [BW-1:0]       wr_addr,
    input  logic [PW-1:0]       wr_data,
    output logic [NBINS*AW-1:0] mem_flat
);
    logic [AW-1:0] acc [NBINS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_first) acc[wr_addr] <= AW'(wr_data);
            else          acc[wr_addr] <= acc[wr_addr] + AW'(wr_data);
        end
    end

    for (genvar g = 0; g < NBINS; g++) begin : g_flat
        assign mem_flat[g*AW +: AW] = acc[g];
    end

    // R3: the window count limit from the sequencer must keep sums from wrapping
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_first) |=> (acc[$past(wr_addr)] >= AW'($past(wr_data))));
endmodule

// File: rtl/est_smooth_cmp.sv
module est_smooth_cmp #(
    parameter int NBINS    = 64,
    parameter int AW       = 20,
    parameter int PW       = 16,
    parameter int MAX_HALF = 7,
    parameter int WLW      = 3,
    localparam int BW      = $clog2(NBINS),
    localparam int HW      = $clog2(MAX_HALF + 1),
    localparam int SW      = AW + $clog2(2*MAX_HALF + 2)
) (
    input  logic [NBINS*AW-1:0] mem_flat,
    input  logic [BW-1:0]       idx,
    input  logic [WLW-1:0]      wlog,
    input  logic [HW-1:0]       half,
    input  logic [PW-1:0]       thresh,
    output logic                above
);
    logic [AW-1:0] acc [NBINS];
    logic [SW-1:0] sum;
    logic [SW-1:0] limit;

    for (genvar g = 0; g < NBINS; g++) begin : g_unpack
        assign acc[g] = mem_flat[g*AW +: AW];
    end

    always_comb begin
        int p;
        sum = '0;
        for (int j = 0; j < 2*MAX_HALF + 1; j++) begin
            p = int'(idx) + j - MAX_HALF;
            if (j >= MAX_HALF - int'(half) && j <= MAX_HALF + int'(half) &&
                p >= 0 && p < NBINS)
                sum = sum + SW'(acc[p[BW-1:0]] >> wlog);
        end
    end

    assign limit = SW'(thresh) * SW'({half, 1'b1});
    assign above = sum > limit;
endmodule

// File: rtl/est_run_track.sv
module est_run_track #(
    parameter int NBINS = 64,
    localparam int BW   = $clog2(NBINS),
    localparam int LW   = $clog2(NBINS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [BW-1:0] idx,
    input  logic          above,
    output logic [BW-1:0] best_start,
    output logic [LW-1:0] best_len
);
    logic [BW-1:0] cur_start;
    logic [LW-1:0] cur_len;
    logic [LW-1:0] grown;

    assign grown = cur_len + LW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (clear) begin
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (step) begin
            if (above) begin
                if (cur_len == '0) cur_start <= idx;
                cur_len <= grown;
                if (grown > best_len) begin
                    best_len   <= grown;
                    best_start <= (cur_len == '0) ? idx : cur_start;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    // R6: the widest run seen so far always covers the open run
    a_r6_best_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        cur_len <= best_len);
    // R6: a run never exceeds the spectrum
    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        best_len <= LW'(NBINS));
endmodule

// File: rtl/est_carrier_finder.sv
module est_carrier_finder
    import est_pkg::*;
#(
    parameter int NBINS    = 64,
    parameter int PW       = 16,
    parameter int MAX_WLOG = 4,
    parameter int MAX_HALF = 7,
    localparam int BW      = $clog2(NBINS),
    localparam int WLW     = $clog2(MAX_WLOG + 1),
    localparam int HW      = $clog2(MAX_HALF + 1),
    localparam int AW      = PW + MAX_WLOG,
    localparam int WCW     = MAX_WLOG + 1,
    localparam int LW      = $clog2(NBINS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_valid,
    input  logic           pwr_sof,
    input  logic [PW-1:0]  pwr_data,
    input  logic [WLW-1:0] cfg_win_log2,
    input  logic [HW-1:0]  cfg_smooth_half,
    input  logic [PW-1:0]  cfg_thresh,
    output logic           det_flag,
    output logic [BW-1:0]  center_bin,
    output logic           done
);
    est_state_e state, state_nx;

    logic [BW-1:0]      bin_cnt;
    logic [WCW-1:0]     win_cnt;
    logic [BW-1:0]      scan_idx;
    logic [WLW-1:0]     wlog_q;
    logic [HW-1:0]      half_q;
    logic [PW-1:0]      thr_q;
    logic [WCW-1:0]     win_last;
    logic               start, last_bin, wr_en, wr_first, above;
    logic [BW-1:0]      wr_addr;
    logic [NBINS*AW-1:0] mem_flat;
    logic [BW-1:0]      best_start;
    logic [LW-1:0]      best_len;
    logic [BW-1:0]      mid;

    assign win_last = WCW'((1 << wlog_q) - 1);
    assign start    = (state == ST_IDLE) && pwr_valid && pwr_sof;
    assign last_bin = bin_cnt == BW'(NBINS - 1);
    assign wr_en    = start || (state == ST_ACCUM && pwr_valid);
    assign wr_addr  = (state == ST_IDLE) ? '0 : bin_cnt;
    assign wr_first = (state == ST_IDLE) || (win_cnt == '0);
    assign mid      = best_start + BW'((best_len - LW'(1)) >> 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, filled, scanned, reported
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ACCUM;
            ST_ACCUM:  if (pwr_valid && last_bin && win_cnt == win_last)
                           state_nx = ST_SCAN;
            ST_SCAN:   if (scan_idx == BW'(NBINS - 1)) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
        endcase
    end

    // counters and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_cnt  <= '0;
            win_cnt  <= '0;
            scan_idx <= '0;
            wlog_q   <= '0;
            half_q   <= '0;
            thr_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    scan_idx <= '0;
                    if (start) begin
                        bin_cnt <= BW'(1 % NBINS);
                        win_cnt <= '0;
                        wlog_q  <= (cfg_win_log2 > WLW'(MAX_WLOG)) ? WLW'(MAX_WLOG)
                                                                   : cfg_win_log2;
                        half_q  <= cfg_smooth_half;
                        thr_q   <= cfg_thresh;
                    end
                end
                ST_ACCUM: begin
                    scan_idx <= '0;
                    if (pwr_valid) begin
                        if (last_bin) begin
                            bin_cnt <= '0;
                            win_cnt <= win_cnt + WCW'(1);
                        end else begin
                            bin_cnt <= bin_cnt + BW'(1);
                        end
                    end
                end
                ST_SCAN:   scan_idx <= scan_idx + BW'(1);
                ST_REPORT: scan_idx <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_flag   <= 1'b0;
            center_bin <= '0;
            done       <= 1'b0;
        end else begin
            done <= (state == ST_REPORT);
            if (state == ST_REPORT) begin
                det_flag   <= best_len != '0;
                center_bin <= (best_len != '0) ? mid : '0;
            end
        end
    end

    est_psd_accum #(.NBINS(NBINS), .PW(PW), .AW(AW)) u_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_first(wr_first),
        .wr_addr(wr_addr), .wr_data(pwr_data), .mem_flat(mem_flat)
    );

    est_smooth_cmp #(.NBINS(NBINS), .AW(AW), .PW(PW), .MAX_HALF(MAX_HALF),
                     .WLW(WLW)) u_smooth (
        .mem_flat(mem_flat), .idx(scan_idx), .wlog(wlog_q), .half(half_q),
        .thresh(thr_q), .above(above)
    );

    est_run_track #(.NBINS(NBINS)) u_runs (
        .clk(clk), .rst_n(rst_n), .clear(start), .step(state == ST_SCAN),
        .idx(scan_idx), .above(above), .best_start(best_start),
        .best_len(best_len)
    );

    // R8: done never lasts two cycles
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a report without detection carries bin 0
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !det_flag) |-> (center_bin == '0));
    // R8: the scan leads only to itself or to the report
    a_r8_scan_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |=> (state == ST_SCAN || state == ST_REPORT));
endmodule

// File: tb/est_carrier_finder_test.sv
module est_carrier_finder_test;
    localparam int NB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_valid = 1'b0, pwr_sof = 1'b0;
    logic [15:0] pwr_data = '0;
    logic [2:0]  cfg_win_log2 = '0, cfg_smooth_half = '0;
    logic [15:0] cfg_thresh = '0;
    logic        det_flag, done;
    logic [5:0]  center_bin;

    int errors = 0, checks = 0;
    int cyc = 0, last_cyc = 0, done_cyc = 0;
    int res_cnt = 0, res_det = 0, res_ctr = 0, double_cnt = 0;
    bit prev_done = 0;
    int base [NB];
    int wstep = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (done) begin
            res_cnt++;
            res_det = det_flag;
            res_ctr = center_bin;
            done_cyc = cyc;
            if (prev_done) double_cnt++;
        end
        prev_done = done;
    end

    est_carrier_finder uut (
        .clk(clk), .rst_n(rst_n), .pwr_valid(pwr_valid), .pwr_sof(pwr_sof),
        .pwr_data(pwr_data), .cfg_win_log2(cfg_win_log2),
        .cfg_smooth_half(cfg_smooth_half), .cfg_thresh(cfg_thresh),
        .det_flag(det_flag), .center_bin(center_bin), .done(done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int val(int w, int k);
        return (base[k] == 0) ? 0 : base[k] + wstep * w;
    endfunction

    function automatic void clear_base();
        for (int k = 0; k < NB; k++) base[k] = 0;
        wstep = 0;
    endfunction

    function automatic void model(int wl, int h, int thr, output int edet,
                                  output int ectr);
        int avg [NB];
        int cs, cl, bs, bl, s;
        for (int k = 0; k < NB; k++) begin
            s = 0;
            for (int w = 0; w < (1 << wl); w++) s += val(w, k);
            avg[k] = s >> wl;
        end
        cs = 0; cl = 0; bs = 0; bl = 0;
        for (int k = 0; k < NB; k++) begin
            s = 0;
            for (int j = k - h; j <= k + h; j++)
                if (j >= 0 && j < NB) s += avg[j];
            if (s > thr * (2*h + 1)) begin
                if (cl == 0) cs = k;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else cl = 0;
        end
        edet = (bl != 0);
        ectr = (bl != 0) ? bs + (bl - 1) / 2 : 0;
    endfunction

    // caller stands at a negedge; returns at a negedge with valid low
    task automatic feed(int wl, int h, int thr, bit gaps, int chg_at);
        cfg_win_log2 = 3'(wl); cfg_smooth_half = 3'(h); cfg_thresh = 16'(thr);
        for (int w = 0; w < (1 << wl); w++) begin
            for (int k = 0; k < NB; k++) begin
                if (gaps && (k % 7) == 3) begin
                    pwr_valid = 1'b0;
                    @(negedge clk);
                end
                if (w == 0 && k == chg_at) begin
                    cfg_thresh = 16'd60000; cfg_smooth_half = 3'd7;
                    cfg_win_log2 = 3'd0;
                end
                pwr_valid = 1'b1; pwr_sof = (k == 0); pwr_data = 16'(val(w, k));
                last_cyc = cyc;
                @(negedge clk);
            end
        end
        pwr_valid = 1'b0; pwr_sof = 1'b0;
    endtask

    task automatic wait_result();
        int n0 = res_cnt;
        while (res_cnt == n0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_and_check(string req, int wl, int h, int thr, bit gaps);
        int ed, ec;
        model(wl, h, thr, ed, ec);
        @(negedge clk);
        feed(wl, h, thr, gaps, -1);
        wait_result();
        check(res_det == ed, {req, " det"}, res_det, ed);
        check(res_ctr == ec, {req, " center"}, res_ctr, ec);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(det_flag == 0, "R1 det", det_flag, 0);
        check(center_bin == 0, "R1 center", center_bin, 0);
        check(done == 0, "R1 done", done, 0);
    endtask

    task automatic t_basic();
        int ed, ec;
        clear_base();
        for (int k = 10; k <= 20; k++) base[k] = 1000;
        model(0, 0, 500, ed, ec);
        @(negedge clk);
        // R2: idle samples without a window marker are ignored
        for (int i = 0; i < 10; i++) begin
            pwr_valid = 1'b1; pwr_sof = 1'b0; pwr_data = 16'd50000;
            @(negedge clk);
        end
        feed(0, 0, 500, 1'b1, -1);
        wait_result();
        check(res_det == ed, "R5 det", res_det, ed);
        check(res_ctr == ec, "R2 R6 center", res_ctr, ec);
        check(done_cyc - last_cyc == NB + 2, "R8 latency", done_cyc - last_cyc, NB + 2);
        repeat (20) @(negedge clk);
        check(det_flag == 1 && center_bin == 6'(ec), "R8 hold", center_bin, ec);
    endtask

    task automatic t_average();
        clear_base();
        for (int k = 30; k <= 33; k++) base[k] = 100;
        wstep = 1;  // windows give 100..103, floor(406/4)=101
        run_and_check("R3 strict", 2, 0, 101, 1'b0);
        run_and_check("R3 floor", 2, 0, 100, 1'b0);
    endtask

    task automatic t_edges();
        clear_base();
        base[0] = 500;
        run_and_check("R4 low edge", 0, 2, 99, 1'b0);
        run_and_check("R7 none", 0, 2, 100, 1'b0);
        clear_base();
        base[NB-1] = 500;
        run_and_check("R4 high edge", 0, 2, 99, 1'b0);
    endtask

    task automatic t_runs();
        clear_base();
        for (int k = 5; k <= 7; k++) base[k] = 900;
        for (int k = 40; k <= 49; k++) base[k] = 900;
        run_and_check("R6 longest", 0, 0, 400, 1'b0);
        clear_base();
        for (int k = 2; k <= 5; k++) base[k] = 900;
        for (int k = 20; k <= 23; k++) base[k] = 900;
        run_and_check("R6 tie", 0, 0, 400, 1'b0);
    endtask

    task automatic t_config();
        int ed, ec;
        clear_base();
        base[8] = 100; base[9] = 100;
        model(0, 0, 50, ed, ec);
        @(negedge clk);
        feed(0, 0, 50, 1'b0, 5);
        wait_result();
        check(res_det == ed, "R10 det", res_det, ed);
        check(res_ctr == ec, "R10 center", res_ctr, ec);
    endtask

    task automatic t_b2b();
        int ea_d, ea_c, eb_d, eb_c;
        clear_base();
        for (int k = 12; k <= 16; k++) base[k] = 700;
        model(1, 1, 300, ea_d, ea_c);
        @(negedge clk);
        feed(1, 1, 300, 1'b0, -1);
        // R9: junk flagged as window starts during the scan
        for (int i = 0; i < 20; i++) begin
            pwr_valid = 1'b1; pwr_sof = 1'b1; pwr_data = 16'd65000;
            @(negedge clk);
        end
        pwr_valid = 1'b0; pwr_sof = 1'b0;
        while (!done) @(negedge clk);
        check(det_flag == ea_d[0], "R9 det A", det_flag, ea_d);
        check(center_bin == 6'(ea_c), "R9 center A", center_bin, ea_c);
        clear_base();
        base[0] = 800; base[1] = 800; base[2] = 800;
        model(0, 0, 300, eb_d, eb_c);
        feed(0, 0, 300, 1'b0, -1);
        wait_result();
        check(res_det == eb_d, "R9 det B", res_det, eb_d);
        check(res_ctr == eb_c, "R9 center B", res_ctr, eb_c);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_average();
        t_edges();
        t_runs();
        t_config();
        t_b2b();
        check(double_cnt == 0, "R8 single pulse", double_cnt, 0);
        check(res_cnt == 11, "R8 pulse count", res_cnt, 11);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule